// File: doc/BRIEF.md
# Segmented Road Coincidence Trigger

This block forms the track trigger decision for one angular sector of a four-layer silicon strip tracker. Each strobe presents one binary hit bit per strip on every layer. The block first coarsens the hits into segments. On the innermost and outermost layers a segment is the OR of 32 adjacent strips. On the two middle layers a segment is the OR of 16 adjacent strips. The segment hits are then compared against a programmable table of roads. A road names one segment on each layer, and it represents a track from the interaction point.

A road fires in one of two modes. In the strict mode all four of its segments must be hit. In the relaxed mode three or more must be hit, and the innermost layer must be among them. For each strobe the block reports one match bit per road and a sector accept bit, which is the OR of all road matches. The road table is cleared by reset and is loaded through a write port while no decision is being made. One instance serves one sector, so a full detector uses one instance per sector.

Top module: `road_trig_top`

## Requirements
- R1: After reset, valid_o, accept_o and road_hit_o are all zero and every road-table entry is invalid, so a strobe with every strip hit produces no road match.
- R2: Hits and mode_i are captured on the rising edge at which strobe_i is high. The result is registered on the next rising edge, and valid_o is high for exactly that one cycle. While valid_o is low, accept_o and road_hit_o are zero.
- R3: On layers 0 (innermost) and 3 (outermost), strip s belongs to segment floor(s/32). With 512 strips this gives 16 segments.
- R4: On layers 1 and 2, strip s belongs to segment floor(s/16). With 512 strips this gives 32 segments.
- R5: When mode_i = 1 (strict mode), a valid road matches only when its segments on all four layers are hit.
- R6: When mode_i = 0 (relaxed mode), a valid road matches when its layer-0 segment is hit and at least two of its layer-1, layer-2 and layer-3 segments are hit.
- R7: In relaxed mode, a road whose segments are hit on layers 1, 2 and 3 but not on layer 0 does not match.
- R8: accept_o equals the OR of all bits of road_hit_o.
- R9: When wr_en_i is high at a rising edge, entry wr_addr_i is replaced by wr_data_i. The entry layout is as follows: bit 18 is valid, bits 17:14 are the layer-0 segment, bits 13:9 are the layer-1 segment, bits 8:4 are the layer-2 segment, and bits 3:0 are the layer-3 segment. An entry whose valid bit is 0 never matches.
- R10: A change of mode_i after the strobe edge has no effect on that strobe's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Hits and mode are valid this cycle |
| mode_i | input | 1 | 0 = relaxed mode (three of four layers, including layer 0), 1 = strict mode (all four layers) |
| hits_l0_i | input | STRIPS (512) | Strip hits, innermost layer |
| hits_l1_i | input | STRIPS (512) | Strip hits, layer 1 |
| hits_l2_i | input | STRIPS (512) | Strip hits, layer 2 |
| hits_l3_i | input | STRIPS (512) | Strip hits, outermost layer |
| wr_en_i | input | 1 | Road table write enable |
| wr_addr_i | input | clog2(NUM_ROADS) (5) | Road table write index |
| wr_data_i | input | 19 | Road entry: valid bit and four segment indices |
| valid_o | output | 1 | Decision valid |
| accept_o | output | 1 | Sector accept |
| road_hit_o | output | NUM_ROADS (32) | Match bit per road |

## Verification
Single hits placed at the first strip and the last strip of a road's segment groups show whether the coarsening uses the right group size on each layer. A hit one strip outside a group shows that it does not spill into the neighbouring segment. For every road, the bench removes each layer in turn and runs the pattern under both modes. This separates the four-layer rule from the three-layer rule, and it shows that a missing inner layer vetoes the road while a missing middle or outer layer does not. Sparse random hit patterns test overlapping roads and the accept OR, and an all-hit strobe on an empty table tests the reset state. A mode change right after the strobe tests when the mode is sampled.

// File: rtl/road_trig_pkg.sv
package road_trig_pkg;
  localparam int NUM_LAYERS = 4;

  typedef enum logic {
    MODE_INNER3 = 1'b0,
    MODE_ALL4   = 1'b1
  } match_mode_e;
endpackage

// File: rtl/strip_merge.sv
module strip_merge #(
  parameter int STRIPS = 512,
  parameter int GROUP  = 32,
  localparam int NSEG  = STRIPS / GROUP
) (
  input  logic [STRIPS-1:0] strips_i,
  output logic [NSEG-1:0]   seg_o
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign seg_o[g] = |strips_i[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/road_table.sv
module road_table #(
  parameter int NUM_ROADS = 32,
  parameter int EW        = 19,
  localparam int AW       = $clog2(NUM_ROADS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [EW-1:0] wr_data_i,
  output logic [EW-1:0] entries_o [NUM_ROADS]
);
  logic [EW-1:0] entries_q [NUM_ROADS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_ROADS; r++) entries_q[r] <= '0;
    end else if (wr_en_i) begin
      entries_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign entries_o = entries_q;

  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_chk
    // R9: a write lands in the addressed entry
    p_wr_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == AW'(r)) |=> entries_o[r] == $past(wr_data_i));
  end
endmodule

// File: rtl/road_match.sv
module road_match
  import road_trig_pkg::*;
#(
  parameter int NSO       = 16,
  parameter int NSM       = 32,
  parameter int NUM_ROADS = 32,
  localparam int OW       = $clog2(NSO),
  localparam int MW       = $clog2(NSM),
  localparam int EW       = 1 + 2*OW + 2*MW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NSO-1:0]       seg0_i,
  input  logic [NSM-1:0]       seg1_i,
  input  logic [NSM-1:0]       seg2_i,
  input  logic [NSO-1:0]       seg3_i,
  input  match_mode_e          mode_i,
  input  logic [EW-1:0]        entries_i [NUM_ROADS],
  output logic [NUM_ROADS-1:0] match_o
);
  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
    logic          vld;
    logic [OW-1:0] i0, i3;
    logic [MW-1:0] i1, i2;
    logic [3:0]    lh;
    logic          ok3, ok4;

    assign vld = entries_i[r][EW-1];
    assign i0  = entries_i[r][2*OW+2*MW-1 -: OW];
    assign i1  = entries_i[r][OW+2*MW-1 -: MW];
    assign i2  = entries_i[r][OW+MW-1 -: MW];
    assign i3  = entries_i[r][OW-1:0];
    assign lh  = {seg3_i[i3], seg2_i[i2], seg1_i[i1], seg0_i[i0]};
    // inner layer mandatory, any two of the other three
    assign ok3 = lh[0] & ((lh[1] & lh[2]) | (lh[1] & lh[3]) | (lh[2] & lh[3]));
    assign ok4 = &lh;
    assign match_o[r] = vld & ((mode_i == MODE_ALL4) ? ok4 : ok3);

    p_match_vld_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[r] |-> entries_i[r][EW-1]);
    p_match_inner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_o[r] |-> seg0_i[i0]);
    p_match_all4_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o[r] && mode_i == MODE_ALL4) |-> $countones(lh) == 4);
  end
endmodule

// File: rtl/road_trig_top.sv
module road_trig_top
  import road_trig_pkg::*;
#(
  parameter int STRIPS    = 512,
  parameter int GRP_OUTER = 32,
  parameter int GRP_MID   = 16,
  parameter int NUM_ROADS = 32,
  localparam int NSO      = STRIPS / GRP_OUTER,
  localparam int NSM      = STRIPS / GRP_MID,
  localparam int EW       = 1 + 2*$clog2(NSO) + 2*$clog2(NSM),
  localparam int AW       = $clog2(NUM_ROADS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic                 mode_i,
  input  logic [STRIPS-1:0]    hits_l0_i,
  input  logic [STRIPS-1:0]    hits_l1_i,
  input  logic [STRIPS-1:0]    hits_l2_i,
  input  logic [STRIPS-1:0]    hits_l3_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [EW-1:0]        wr_data_i,
  output logic                 valid_o,
  output logic                 accept_o,
  output logic [NUM_ROADS-1:0] road_hit_o
);
  logic [NSO-1:0] seg0_d, seg3_d, seg0_q, seg3_q;
  logic [NSM-1:0] seg1_d, seg2_d, seg1_q, seg2_q;
  match_mode_e    mode_q;
  logic           s1_vld_q;
  logic [EW-1:0]  entries [NUM_ROADS];
  logic [NUM_ROADS-1:0] match;

  strip_merge #(.STRIPS(STRIPS), .GROUP(GRP_OUTER)) i_merge_l0 (.strips_i(hits_l0_i), .seg_o(seg0_d));
  strip_merge #(.STRIPS(STRIPS), .GROUP(GRP_MID))   i_merge_l1 (.strips_i(hits_l1_i), .seg_o(seg1_d));
  strip_merge #(.STRIPS(STRIPS), .GROUP(GRP_MID))   i_merge_l2 (.strips_i(hits_l2_i), .seg_o(seg2_d));
  strip_merge #(.STRIPS(STRIPS), .GROUP(GRP_OUTER)) i_merge_l3 (.strips_i(hits_l3_i), .seg_o(seg3_d));

  // stage 1: segments and mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg0_q   <= '0;
      seg1_q   <= '0;
      seg2_q   <= '0;
      seg3_q   <= '0;
      mode_q   <= MODE_INNER3;
      s1_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= strobe_i;
      if (strobe_i) begin
        seg0_q <= seg0_d;
        seg1_q <= seg1_d;
        seg2_q <= seg2_d;
        seg3_q <= seg3_d;
        mode_q <= match_mode_e'(mode_i);
      end
    end
  end

  road_table #(.NUM_ROADS(NUM_ROADS), .EW(EW)) i_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .entries_o(entries)
  );

  road_match #(.NSO(NSO), .NSM(NSM), .NUM_ROADS(NUM_ROADS)) i_match (
    .clk_i, .rst_ni,
    .seg0_i(seg0_q), .seg1_i(seg1_q), .seg2_i(seg2_q), .seg3_i(seg3_q),
    .mode_i(mode_q), .entries_i(entries), .match_o(match)
  );

  // stage 2: decision, zero when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      accept_o   <= 1'b0;
      road_hit_o <= '0;
    end else begin
      valid_o    <= s1_vld_q;
      accept_o   <= s1_vld_q & (|match);
      road_hit_o <= s1_vld_q ? match : '0;
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> ##2 valid_o);
  p_valid_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(strobe_i, 2));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!accept_o && road_hit_o == '0));
  p_accept_or_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o == (road_hit_o != '0));
endmodule

// File: tb/test_road_trig_top.sv
`timescale 1ns/1ps
module test_road_trig_top;
  localparam int STRIPS = 512;
  localparam int NR     = 16;
  localparam int EW     = 19;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic strobe_i = 1'b0, mode_i = 1'b0, wr_en_i = 1'b0;
  logic [STRIPS-1:0] h [4];
  logic [3:0]  wr_addr_i = '0;
  logic [EW-1:0] wr_data_i = '0;
  logic valid_o, accept_o;
  logic [NR-1:0] road_hit_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic       mv [NR];
  int         mi [NR][4];

  always #2 clk_i = ~clk_i;

  road_trig_top #(.NUM_ROADS(NR)) i_road_trig_top (
    .clk_i, .rst_ni, .strobe_i, .mode_i,
    .hits_l0_i(h[0]), .hits_l1_i(h[1]), .hits_l2_i(h[2]), .hits_l3_i(h[3]),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .valid_o, .accept_o, .road_hit_o
  );

  function automatic int grp(int l);
    return (l == 0 || l == 3) ? 32 : 16;
  endfunction

  function automatic bit seg_hit(int l, int idx);
    for (int j = 0; j < grp(l); j++)
      if (h[l][idx*grp(l) + j]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [NR-1:0] expect_hits(bit md);
    logic [NR-1:0] e = '0;
    for (int r = 0; r < NR; r++) begin
      bit b0, b1, b2, b3;
      int c;
      b0 = seg_hit(0, mi[r][0]); b1 = seg_hit(1, mi[r][1]);
      b2 = seg_hit(2, mi[r][2]); b3 = seg_hit(3, mi[r][3]);
      c = int'(b0) + int'(b1) + int'(b2) + int'(b3);
      e[r] = mv[r] && (md ? (c == 4) : (b0 && c >= 3));
    end
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_road(int a, bit v, int i0, int i1, int i2, int i3);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_addr_i = 4'(a);
    wr_data_i = {v, 4'(i0), 5'(i1), 5'(i2), 4'(i3)};
    mv[a] = v; mi[a][0] = i0; mi[a][1] = i1; mi[a][2] = i2; mi[a][3] = i3;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // strobe current hits; optionally flip mode right after the sampling edge
  task automatic run(string req, bit md, bit flip);
    logic [NR-1:0] e;
    e = expect_hits(md);
    @(negedge clk_i);
    strobe_i = 1'b1; mode_i = md;
    @(negedge clk_i);
    strobe_i = 1'b0;
    if (flip) mode_i = ~md;
    @(negedge clk_i);
    chk({req, " valid"}, 32'(valid_o), 32'd1);
    chk({req, " road_hit"}, 32'(road_hit_o), 32'(e));
    chk({req, " R8 accept"}, 32'(accept_o), 32'(|e));
    @(negedge clk_i);
    chk("R2 valid drops", 32'(valid_o), 32'd0);
    chk("R2 idle outputs", 32'({accept_o, road_hit_o}), 32'd0);
  endtask

  task automatic clear_hits();
    for (int l = 0; l < 4; l++) h[l] = '0;
  endtask

  task automatic road_hits(int r, int skip, int off);
    clear_hits();
    for (int l = 0; l < 4; l++)
      if (l != skip) h[l][mi[r][l]*grp(l) + (off % grp(l))] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_hits();
    for (int r = 0; r < NR; r++) begin
      mv[r] = 0;
      for (int l = 0; l < 4; l++) mi[r][l] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset outputs", 32'({valid_o, accept_o, road_hit_o}), 32'd0);

    // R1: empty table never matches
    for (int l = 0; l < 4; l++) h[l] = '1;
    run("R1 empty table", 1'b0, 1'b0);

    // load table
    write_road(0, 1, 5, 20, 7, 15);
    for (int r = 1; r < NR; r++)
      write_road(r, r != 13, (r*3) % 16, (r*7) % 32, (r*11) % 32, (r*5) % 16);

    // R3/R4 group boundaries: first/last strips of a group
    clear_hits();
    h[0][160] = 1; h[1][335] = 1; h[2][112] = 1; h[3][511] = 1;
    run("R3 R4 boundary strips R5", 1'b1, 1'b0);
    chk("R3 R4 road0 fires", 32'(road_hit_o[0]), 32'd0); // already idle; keep model path below
    clear_hits();
    h[0][160] = 1; h[1][335] = 1; h[2][112] = 1; h[3][511] = 1;
    run("R6 boundary relaxed", 1'b0, 1'b0);
    // neighbour strips fall into adjacent segments
    h[0][160] = 0; h[0][159] = 1;
    run("R3 outer neighbour strip", 1'b0, 1'b0);
    h[0][159] = 0; h[0][191] = 1;
    h[1][335] = 0; h[1][336] = 1;
    run("R4 middle neighbour strip", 1'b1, 1'b0);

    // R7: inner missing, R6: each other layer missing
    road_hits(0, 0, 0);
    run("R7 inner missing relaxed", 1'b0, 1'b0);
    for (int s = 1; s < 4; s++) begin
      road_hits(0, s, 3);
      run("R6 one outer layer missing", 1'b0, 1'b0);
      run("R5 one layer missing strict", 1'b1, 1'b0);
    end

    // R10: mode flipped after sampling edge
    road_hits(0, 2, 1);
    run("R10 mode sampled with hits", 1'b0, 1'b1);
    road_hits(0, 4, 1);
    run("R10 strict then flip", 1'b1, 1'b1);

    // sweep: every road, every missing layer (4 = none), both modes
    for (int r = 0; r < NR; r++)
      for (int s = 0; s < 5; s++)
        for (int m = 0; m < 2; m++) begin
          road_hits(r, s, r*5 + s*7);
          run(m ? "R5 sweep strict" : "R6 R7 R9 sweep relaxed", m[0], 1'b0);
        end

    // sparse random patterns
    for (int t = 0; t < 200; t++) begin
      clear_hits();
      for (int l = 0; l < 4; l++)
        for (int k = 0; k < 8; k++) h[l][$urandom_range(STRIPS-1, 0)] = 1'b1;
      run("R8 random pattern", t[0], 1'b0);
    end

    // R9: invalidate road 0, rewrite, check behaviour changes
    write_road(0, 0, 5, 20, 7, 15);
    road_hits(0, 4, 0);
    run("R9 invalid entry", 1'b1, 1'b0);
    write_road(0, 1, 5, 20, 7, 15);
    run("R9 rewritten entry", 1'b1, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule